// File: doc/BRIEF.md
# Sensor Frame Timing Generator

This block drives the readout timing of a raw-pixel image sensor. It walks a column counter and a row counter across the whole physical array, including the margin pixels and rows that lie outside the picture, and its horizontal and vertical blanking. From that position it produces a pixel-valid strobe for the centred picture window, a one-clock marker at the first column of every line, and a one-clock marker at the first column of the first row of every frame.

The frame rate is lowered by appending blank lines to the end of each frame. The line length and the pixel rate inside a line never change. A register input gives the number of added lines. The block samples it only on the clock edge that opens a new frame, so a frame is never built from two different lengths. A synchronous restart input returns the timing to the top of a frame at any time and samples the extra-line count again. Reset does the same.

All outputs are registered. They always describe the same pixel position: the one held in the counters.

Top module: `frame_timing_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `col_addr` and `row_addr` are 0, `frame_start` and `line_start` are 1, and `pix_valid` is 0.
- R2: `col_addr` counts from 0 up to ARRAY_W+HBLANK-1 (799 by default), one step per clock, and then returns to 0. A line is always exactly ARRAY_W+HBLANK clocks long, whatever the extra-line count.
- R3: `row_addr` holds its value inside a line and steps by one when the column wraps. After row ARRAY_H+VBLANK+E-1, where E is the sampled extra-line count, it returns to 0. A frame is therefore (ARRAY_H+VBLANK+E)×(ARRAY_W+HBLANK) clocks long.
- R4: `pix_valid` is 1 exactly when the column is in ACT_X0..ACT_X0+ACT_W-1 and the row is in ACT_Y0..ACT_Y0+ACT_H-1. By default these are columns 2..641 and rows 2..481.
- R5: `line_start` is 1 exactly when `col_addr` is 0, on every row including the blank rows.
- R6: `frame_start` is 1 exactly when `col_addr` and `row_addr` are both 0.
- R7: `extra_lines` is sampled only on the edge that enters row 0, column 0. A change to it during a frame has no effect on that frame's length and takes effect in the next frame.
- R8: When `restart` is high at a clock edge, the next outputs show column 0, row 0 with `frame_start` set. The frame that follows uses the `extra_lines` value present at that edge.
- R9: The largest extra-line value (all ones, EXTRA_W bits) is honoured without overflow: the row count reaches ARRAY_H+VBLANK+2^EXTRA_W-2. With the defaults this makes a frame more than 100 times the length of the unpadded frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous return to top of frame |
| extra_lines | input | EXTRA_W | Blank lines appended per frame |
| col_addr | output | COL_W | Current column, array plus horizontal blanking |
| row_addr | output | ROW_W | Current row, array plus vertical blanking and padding |
| pix_valid | output | 1 | Position inside the active picture window |
| line_start | output | 1 | First column of any row |
| frame_start | output | 1 | First column of row 0 |

## Verification
The bench uses a reduced geometry, so that frames are short. It compares every output on every cycle with a reference position model. The stimulus is random extra-line values held for random stretches, with occasional restarts and resets mixed in. Frame lengths measured with zero, mid-range and all-ones padding show whether rows are added only at the frame tail while the line length stays fixed. A change of the extra-line count in mid-frame shows whether the value is sampled only at the frame boundary. A restart in mid-frame shows whether the counters return to the top at once and whether the count is sampled again there.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef struct packed {
    logic pix_valid;
    logic line_start;
    logic frame_start;
  } fts_flags_t;

endpackage

// File: rtl/fts_col_counter.sv
module fts_col_counter #(
  parameter int LINE_LEN = 800,
  parameter int COL_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [COL_W-1:0] col_q,
  output logic [COL_W-1:0] col_next,
  output logic             line_wrap
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_LEN - 1);

  assign line_wrap = (col_q == COL_LAST);

  always_comb begin
    if (rst || restart)  col_next = '0;
    else if (line_wrap)  col_next = '0;
    else                 col_next = col_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    col_q <= col_next;
  end

endmodule

// File: rtl/fts_row_counter.sv
module fts_row_counter #(
  parameter int ROWS_FIXED = 500,
  parameter int EXTRA_W    = 16,
  parameter int ROW_W      = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               line_wrap,
  input  logic [EXTRA_W-1:0] extra_in,
  output logic [ROW_W-1:0]   row_q,
  output logic [ROW_W-1:0]   row_next,
  output logic               frame_wrap
);

  localparam logic [ROW_W-1:0] FIXED_LAST = ROW_W'(ROWS_FIXED - 1);

  logic [EXTRA_W-1:0] extra_q;
  logic [ROW_W-1:0]   row_last;

  // Last row index of the frame in progress; extra_q is frozen for the frame.
  assign row_last   = FIXED_LAST + ROW_W'(extra_q);
  assign frame_wrap = line_wrap && (row_q == row_last);

  always_comb begin
    if (rst || restart)  row_next = '0;
    else if (frame_wrap) row_next = '0;
    else if (line_wrap)  row_next = row_q + 1'b1;
    else                 row_next = row_q;
  end

  always_ff @(posedge clk) begin
    row_q <= row_next;
    if (rst || restart || frame_wrap) begin
      extra_q <= extra_in;
    end
  end

endmodule

// File: rtl/fts_window_decode.sv
module fts_window_decode
  import fts_pkg::*;
#(
  parameter int ACT_X0 = 2,
  parameter int ACT_W  = 640,
  parameter int ACT_Y0 = 2,
  parameter int ACT_H  = 480,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 17
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output fts_flags_t       flags
);

  localparam logic [COL_W-1:0] X_END = COL_W'(ACT_X0 + ACT_W);
  localparam logic [ROW_W-1:0] Y_END = ROW_W'(ACT_Y0 + ACT_H);

  logic x_lo_ok;
  logic y_lo_ok;

  generate
    if (ACT_X0 == 0) begin : g_x_nomargin
      assign x_lo_ok = 1'b1;
    end else begin : g_x_margin
      assign x_lo_ok = (col >= COL_W'(ACT_X0));
    end
    if (ACT_Y0 == 0) begin : g_y_nomargin
      assign y_lo_ok = 1'b1;
    end else begin : g_y_margin
      assign y_lo_ok = (row >= ROW_W'(ACT_Y0));
    end
  endgenerate

  always_comb begin
    flags.pix_valid   = x_lo_ok && (col < X_END) && y_lo_ok && (row < Y_END);
    flags.line_start  = (col == '0);
    flags.frame_start = (col == '0) && (row == '0);
  end

endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import fts_pkg::*;
#(
  parameter int ARRAY_W = 644,
  parameter int ARRAY_H = 484,
  parameter int HBLANK  = 156,
  parameter int VBLANK  = 16,
  parameter int EXTRA_W = 16,
  parameter int ACT_X0  = 2,
  parameter int ACT_W   = 640,
  parameter int ACT_Y0  = 2,
  parameter int ACT_H   = 480,
  localparam int LINE_LEN   = ARRAY_W + HBLANK,
  localparam int ROWS_FIXED = ARRAY_H + VBLANK,
  localparam int COL_W      = $clog2(LINE_LEN),
  localparam int ROW_W      = $clog2(ROWS_FIXED + (2 ** EXTRA_W))
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [EXTRA_W-1:0] extra_lines,
  output logic [COL_W-1:0]   col_addr,
  output logic [ROW_W-1:0]   row_addr,
  output logic               pix_valid,
  output logic               line_start,
  output logic               frame_start
);

  logic [COL_W-1:0] col_next;
  logic [ROW_W-1:0] row_next;
  logic             line_wrap;
  logic             frame_wrap;
  fts_flags_t       flags_next;
  fts_flags_t       flags_q;

  fts_col_counter #(
    .LINE_LEN (LINE_LEN),
    .COL_W    (COL_W)
  ) u_col (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .col_q     (col_addr),
    .col_next  (col_next),
    .line_wrap (line_wrap)
  );

  fts_row_counter #(
    .ROWS_FIXED (ROWS_FIXED),
    .EXTRA_W    (EXTRA_W),
    .ROW_W      (ROW_W)
  ) u_row (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .line_wrap  (line_wrap),
    .extra_in   (extra_lines),
    .row_q      (row_addr),
    .row_next   (row_next),
    .frame_wrap (frame_wrap)
  );

  // Decode the position the counters are about to take, so the flag
  // registers line up with the counter registers.
  fts_window_decode #(
    .ACT_X0 (ACT_X0),
    .ACT_W  (ACT_W),
    .ACT_Y0 (ACT_Y0),
    .ACT_H  (ACT_H),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W)
  ) u_win (
    .col   (col_next),
    .row   (row_next),
    .flags (flags_next)
  );

  always_ff @(posedge clk) begin
    flags_q <= flags_next;
  end

  assign pix_valid   = flags_q.pix_valid;
  assign line_start  = flags_q.line_start;
  assign frame_start = flags_q.frame_start;

  logic unused_wrap;
  assign unused_wrap = frame_wrap;

endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int ARRAY_W = 644,
  parameter int ARRAY_H = 484,
  parameter int HBLANK  = 156,
  parameter int VBLANK  = 16,
  parameter int EXTRA_W = 16,
  parameter int ACT_X0  = 2,
  parameter int ACT_W   = 640,
  parameter int ACT_Y0  = 2,
  parameter int ACT_H   = 480,
  localparam int LINE_LEN   = ARRAY_W + HBLANK,
  localparam int ROWS_FIXED = ARRAY_H + VBLANK,
  localparam int COL_W      = $clog2(LINE_LEN),
  localparam int ROW_W      = $clog2(ROWS_FIXED + (2 ** EXTRA_W))
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic [COL_W-1:0] col_addr,
  input logic [ROW_W-1:0] row_addr,
  input logic             pix_valid,
  input logic             line_start,
  input logic             frame_start
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_LEN - 1);

  assert_col_range_R2: assert property (@(posedge clk) disable iff (rst)
    col_addr <= COL_LAST);

  assert_col_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!restart && col_addr != COL_LAST) |=> col_addr == COL_W'($past(col_addr) + 1'b1));

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!restart && col_addr != COL_LAST) |=> row_addr == $past(row_addr));

  assert_valid_window_R4: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (int'(col_addr) >= ACT_X0 && int'(col_addr) < ACT_X0 + ACT_W &&
                   int'(row_addr) >= ACT_Y0 && int'(row_addr) < ACT_Y0 + ACT_H));

  assert_line_start_col0_R5: assert property (@(posedge clk) disable iff (rst)
    line_start |-> col_addr == '0);

  assert_col0_line_start_R5: assert property (@(posedge clk) disable iff (rst)
    col_addr == '0 |-> line_start);

  assert_frame_start_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (line_start && row_addr == '0));

  assert_restart_top_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (frame_start && col_addr == '0 && row_addr == '0));

endmodule

bind frame_timing_gen fts_checker #(
  .ARRAY_W (ARRAY_W),
  .ARRAY_H (ARRAY_H),
  .HBLANK  (HBLANK),
  .VBLANK  (VBLANK),
  .EXTRA_W (EXTRA_W),
  .ACT_X0  (ACT_X0),
  .ACT_W   (ACT_W),
  .ACT_Y0  (ACT_Y0),
  .ACT_H   (ACT_H)
) u_fts_checker (
  .clk         (clk),
  .rst         (rst),
  .restart     (restart),
  .col_addr    (col_addr),
  .row_addr    (row_addr),
  .pix_valid   (pix_valid),
  .line_start  (line_start),
  .frame_start (frame_start)
);

// File: tb/frame_timing_gen_bench.sv
module frame_timing_gen_bench;

  localparam int AW = 12, AH = 8, HB = 4, VB = 2, EW = 4;
  localparam int X0 = 2, XW = 8, Y0 = 2, YH = 4;
  localparam int LINE = AW + HB;
  localparam int FIX  = AH + VB;
  localparam int CW   = $clog2(LINE);
  localparam int RW   = $clog2(FIX + (2 ** EW));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          restart = 1'b0;
  logic [EW-1:0] ext = '0;
  logic [CW-1:0] col_addr;
  logic [RW-1:0] row_addr;
  logic          pix_valid, line_start, frame_start;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  int m_col, m_row, m_ext;
  bit armed = 0;

  always #5 clk = ~clk;

  frame_timing_gen #(
    .ARRAY_W (AW), .ARRAY_H (AH), .HBLANK (HB), .VBLANK (VB), .EXTRA_W (EW),
    .ACT_X0 (X0), .ACT_W (XW), .ACT_Y0 (Y0), .ACT_H (YH)
  ) u_frame_timing_gen (
    .clk (clk), .rst (rst), .restart (restart), .extra_lines (ext),
    .col_addr (col_addr), .row_addr (row_addr), .pix_valid (pix_valid),
    .line_start (line_start), .frame_start (frame_start)
  );

  function automatic int exp_valid(int c, int r);
    return (c >= X0 && c < X0 + XW && r >= Y0 && r < Y0 + YH) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference position model, updated on the same edges as the design.
  always @(posedge clk) begin
    if (rst || restart) begin
      m_col <= 0; m_row <= 0; m_ext <= int'(ext);
    end else if (m_col == LINE - 1) begin
      m_col <= 0;
      if (m_row == FIX + m_ext - 1) begin
        m_row <= 0; m_ext <= int'(ext);
      end else begin
        m_row <= m_row + 1;
      end
    end else begin
      m_col <= m_col + 1;
    end
    armed <= 1'b1;
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (armed) begin
      n_chk++;
      if (int'(col_addr) != m_col || int'(row_addr) != m_row ||
          int'(pix_valid) != exp_valid(m_col, m_row) ||
          int'(line_start) != int'(m_col == 0) ||
          int'(frame_start) != int'(m_col == 0 && m_row == 0)) begin
        n_err++;
        $display("FAIL R2/R3/R4/R5/R6 model cyc %0d col %0d/%0d row %0d/%0d valid %0d/%0d ls %0d fs %0d",
                 cyc, col_addr, m_col, row_addr, m_row, pix_valid,
                 exp_valid(m_col, m_row), line_start, frame_start);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 100000) begin
      n_err++;
      $display("FAIL watchdog actual %0d expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic measure(output int len, output int maxrow);
    do @(negedge clk); while (!frame_start);
    len = 0; maxrow = 0;
    do begin
      @(negedge clk);
      len++;
      if (int'(row_addr) > maxrow) maxrow = int'(row_addr);
    end while (!frame_start);
  endtask

  initial begin
    int len, mx, gap;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 col", int'(col_addr), 0);
    chk("R1 row", int'(row_addr), 0);
    chk("R1 frame_start", int'(frame_start), 1);
    chk("R1 line_start", int'(line_start), 1);
    chk("R1 pix_valid", int'(pix_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle col", int'(col_addr), 1);

    // R3 unpadded frame
    measure(len, mx);
    chk("R3 frame len E=0", len, LINE * FIX);
    chk("R3 max row E=0", mx, FIX - 1);

    // R9 all-ones padding
    ext = '1;
    measure(len, mx);
    chk("R9 frame len E=max", len, LINE * (FIX + 15));
    chk("R9 max row E=max", mx, FIX + 15 - 1);

    // R2 line length unchanged under padding
    do @(negedge clk); while (!line_start);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!line_start);
    chk("R2 line len", gap, LINE);

    // R7 mid-frame change ignored until next frame
    ext = 4'd5;
    do @(negedge clk); while (!frame_start);
    do @(negedge clk); while (!frame_start);
    len = 0;
    repeat (50) begin @(negedge clk); len++; end
    ext = 4'd9;
    do begin @(negedge clk); len++; end while (!frame_start);
    chk("R7 frame len after mid change", len, LINE * (FIX + 5));
    len = 0;
    do begin @(negedge clk); len++; end while (!frame_start);
    chk("R7 next frame len", len, LINE * (FIX + 9));

    // R8 restart mid-frame with new count
    repeat (37) @(negedge clk);
    ext = 4'd2;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    ext = 4'd7;
    chk("R8 col", int'(col_addr), 0);
    chk("R8 row", int'(row_addr), 0);
    chk("R8 frame_start", int'(frame_start), 1);
    len = 0;
    do begin @(negedge clk); len++; end while (!frame_start);
    chk("R8 frame len after restart", len, LINE * (FIX + 2));

    // Random segments, checked by the model each cycle
    for (int s = 0; s < 40; s++) begin
      int unsigned r;
      r = $urandom;
      ext = EW'(r);
      if (r[8:7] == 2'b00) begin
        restart = 1'b1; @(negedge clk); restart = 1'b0;
      end else if (r[11:9] == 3'b000) begin
        rst = 1'b1; @(negedge clk); rst = 1'b0;
      end
      repeat (20 + int'(r[20:12] % 9'd300)) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule